// File: doc/BRIEF.md
# Buffered Output-Compare PWM Timer

A free-running up-counter with a programmable modulo limit drives two output-compare channels. Each channel can toggle its pin when the counter wraps and force the pin to a chosen level when the counter equals the channel's compare value. Together these two actions produce a PWM waveform. The modulo sets the period and the compare value sets the pulse width.

Setting the link bit in the channel 0 control register joins the two compare registers into one buffered pair that drives `pwm_out`. At any time one of the two registers is the active one. Software loads the new duty cycle into the other register, and the pair switches to it only at the next counter wrap, so every period is produced whole. While the pair is linked, the channel 1 control register has no effect and the channel 1 pin follows a general-purpose data bit. A sticky overflow flag, with an interrupt enable, marks each wrap.

Top module: `bufpwm_timer`

## Requirements
- R1: The counter starts at 0. While `cnt_en` is high it increments once per cycle. When its value is equal to or greater than the modulo register (address 0), it returns to 0 on the next cycle. The period is therefore modulo+1 cycles.
- R2: While `cnt_en` is low, the counter, both channel pins and the overflow flag hold their values.
- R3: Each channel control register has bit 0 = toggle on wrap and bit 1 = compare action (1 clears the pin, 0 sets the pin). With both bits set and compare value C ≤ modulo, the pin is high for C+1 cycles of each period. With bit 0 set and bit 1 clear, the pin is low for C+1 cycles of each period.
- R4: When a compare match and a wrap fall in the same cycle, the pin takes the opposite of the compare level. Compare value equal to modulo therefore gives a pin that stays at the pulse level for the whole period.
- R5: Bit 2 of control register 0 (address 3) links the pair onto `pwm_out` under channel 0's control bits. When the link is enabled, compare register 0 (address 1) is active.
- R6: While linked, a write to the inactive compare register does not change the current period. That register becomes active at the next wrap.
- R7: While linked, a write to the active compare register takes effect in the current period.
- R8: If both compare registers are written within one period, the register written later is active after the wrap.
- R9: While linked, `ch1_out` equals bit 0 of the GPIO register (address 7). While unlinked, `ch1_out` is channel 1's own output, driven by compare register 1 (address 2) and control register 1 (address 4).
- R10: Each wrap sets the overflow flag. The flag stays set until bit 0 is written as 1 at address 6; if a clear and a wrap fall in the same cycle, the wrap wins. `irq` is the flag ANDed with bit 0 of the enable register (address 5).
- R11: After reset, `pwm_out`, `ch1_out` and `irq` are 0, the pair is unlinked, and every register reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | 1 | Channel 0 / linked pair output |
| ch1_out | output | 1 | Channel 1 pin (timer output or GPIO) |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest case to bring about is a handover between the two compare registers: the write to the inactive register must land in one period and the change must first appear in the next one. The bench uses the overflow interrupt to align itself to the start of a period. It then measures each period cycle by cycle and places writes at chosen counter positions inside that period. With this it checks that the duty stays unchanged for the rest of the period and switches at the wrap, covering both write orders and writes to the active register. Plain duty is swept over every compare value for several modulo values and both pin polarities, and the expected high counts are computed arithmetically.

// File: rtl/bufpwm_pkg.sv
package bufpwm_pkg;
  typedef enum logic [2:0] {
    A_MOD  = 3'd0,
    A_CMP0 = 3'd1,
    A_CMP1 = 3'd2,
    A_CTL0 = 3'd3,
    A_CTL1 = 3'd4,
    A_IEN  = 3'd5,
    A_FCLR = 3'd6,
    A_GPIO = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic clr;   // 1: drive low on match, 0: drive high on match
    logic toov;  // toggle on wrap
  } ch_ctl_t;
endpackage

// File: rtl/bufpwm_counter.sv
module bufpwm_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] modulo,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  logic [CNT_W-1:0] cnt_nxt;

  assign ovf = cnt_en && (cnt >= modulo);

  always_comb begin
    cnt_nxt = cnt;
    if (cnt_en) begin
      if (ovf) cnt_nxt = '0;
      else     cnt_nxt = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt == '0));
  assert_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt));
endmodule

// File: rtl/bufpwm_select.sv
module bufpwm_select (
  input  logic clk,
  input  logic rst_n,
  input  logic link,
  input  logic ovf,
  input  logic wr_cmp0,
  input  logic wr_cmp1,
  output logic sel
);
  logic pend, pend_nxt, sel_nxt;
  logic wr_inactive, wr_active, pend_w;

  always_comb begin
    wr_inactive = sel ? wr_cmp0 : wr_cmp1;
    wr_active   = sel ? wr_cmp1 : wr_cmp0;
    pend_w      = pend;
    if (wr_inactive)    pend_w = 1'b1;
    else if (wr_active) pend_w = 1'b0;
    sel_nxt  = sel;
    pend_nxt = pend_w;
    if (!link) begin
      sel_nxt  = 1'b0;
      pend_nxt = 1'b0;
    end else if (ovf && pend_w) begin
      sel_nxt  = ~sel;
      pend_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= 1'b0;
      pend <= 1'b0;
    end else begin
      sel  <= sel_nxt;
      pend <= pend_nxt;
    end
  end

  assert_swap_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (link && !ovf) |=> (sel == $past(sel)) || !link);
endmodule

// File: rtl/bufpwm_channel.sv
module bufpwm_channel
  import bufpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             ovf,
  input  ch_ctl_t          ctl,
  output logic             pin
);
  logic match, level, pin_nxt;

  assign match = cnt_en && (cnt == cmp);
  assign level = ~ctl.clr;

  always_comb begin
    pin_nxt = pin;
    if (match)            pin_nxt = level;
    if (ovf && ctl.toov)  pin_nxt = ~pin_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else        pin <= pin_nxt;
  end

  assert_cmp_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !ovf && ctl.clr) |=> !pin);
  assert_cmp_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !ovf && !ctl.clr) |=> pin);
endmodule

// File: rtl/bufpwm_timer.sv
module bufpwm_timer
  import bufpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out,
  output logic             ch1_out,
  output logic             irq
);
  localparam int NCH = 2;

  logic [CNT_W-1:0] mod_q, cmp0_q, cmp1_q;
  ch_ctl_t          ctl0_q, ctl1_q;
  logic             link_q, ien_q, gpio_q, flag_q, flag_nxt;
  logic [CNT_W-1:0] cnt;
  logic             ovf, sel;
  logic             wr_mod, wr_cmp0, wr_cmp1, wr_ctl0, wr_ctl1, wr_ien, wr_fclr, wr_gpio;
  logic [CNT_W-1:0] ch_cmp [NCH];
  ch_ctl_t          ch_ctl [NCH];
  logic [NCH-1:0]   ch_pin;

  assign wr_mod  = wr_en && (wr_addr == A_MOD);
  assign wr_cmp0 = wr_en && (wr_addr == A_CMP0);
  assign wr_cmp1 = wr_en && (wr_addr == A_CMP1);
  assign wr_ctl0 = wr_en && (wr_addr == A_CTL0);
  assign wr_ctl1 = wr_en && (wr_addr == A_CTL1);
  assign wr_ien  = wr_en && (wr_addr == A_IEN);
  assign wr_fclr = wr_en && (wr_addr == A_FCLR);
  assign wr_gpio = wr_en && (wr_addr == A_GPIO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q  <= '0;
      cmp0_q <= '0;
      cmp1_q <= '0;
      ctl0_q <= '0;
      ctl1_q <= '0;
      link_q <= 1'b0;
      ien_q  <= 1'b0;
      gpio_q <= 1'b0;
    end else begin
      if (wr_mod)  mod_q  <= wr_data;
      if (wr_cmp0) cmp0_q <= wr_data;
      if (wr_cmp1) cmp1_q <= wr_data;
      if (wr_ctl0) begin
        ctl0_q <= '{clr: wr_data[1], toov: wr_data[0]};
        link_q <= wr_data[2];
      end
      if (wr_ctl1) ctl1_q <= '{clr: wr_data[1], toov: wr_data[0]};
      if (wr_ien)  ien_q  <= wr_data[0];
      if (wr_gpio) gpio_q <= wr_data[0];
    end
  end

  always_comb begin
    flag_nxt = flag_q;
    if (wr_fclr && wr_data[0]) flag_nxt = 1'b0;
    if (ovf)                   flag_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_nxt;
  end

  bufpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .modulo(mod_q),
    .cnt(cnt), .ovf(ovf)
  );

  bufpwm_select u_sel (
    .clk(clk), .rst_n(rst_n), .link(link_q), .ovf(ovf),
    .wr_cmp0(wr_cmp0), .wr_cmp1(wr_cmp1), .sel(sel)
  );

  assign ch_cmp[0] = (link_q && sel) ? cmp1_q : cmp0_q;
  assign ch_cmp[1] = cmp1_q;
  assign ch_ctl[0] = ctl0_q;
  assign ch_ctl[1] = ctl1_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    bufpwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt(cnt),
      .cmp(ch_cmp[i]), .ovf(ovf), .ctl(ch_ctl[i]), .pin(ch_pin[i])
    );
  end

  assign pwm_out = ch_pin[0];
  assign ch1_out = link_q ? gpio_q : ch_pin[1];
  assign irq     = flag_q & ien_q;

  assert_link_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_q) |-> !sel);
  assert_pin_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(pwm_out));
  assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag_q);
  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !wr_fclr) |=> flag_q);
endmodule

// File: tb/bufpwm_timer_test.sv
module bufpwm_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic pwm_out, ch1_out, irq;
  int total = 0;
  int bad = 0;
  int cur_mod = 0;

  bufpwm_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .ch1_out(ch1_out), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sync_wrap();
    wr(3'd6, 1);
    while (!irq) @(negedge clk);
  endtask

  // one period from counter value 0; flag cleared at index 0, up to two writes
  task automatic period(input int i1, input logic [2:0] a1, input int d1,
                        input int i2, input logic [2:0] a2, input int d2,
                        output int hi);
    hi = 0;
    for (int i = 0; i <= cur_mod; i++) begin
      if (pwm_out) hi++;
      if (i == 2) chk("R10 flag cleared", int'(irq), 0);
      wr_en = 1'b0;
      if (i == 0) begin wr_en = 1'b1; wr_addr = 3'd6; wr_data = W'(1); end
      else if (i == i1) begin wr_en = 1'b1; wr_addr = a1; wr_data = W'(d1); end
      else if (i == i2) begin wr_en = 1'b1; wr_addr = a2; wr_data = W'(d2); end
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic duty(input bit use_ch1, input int m, output int hi);
    repeat (2 * (m + 1)) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 4 * (m + 1); i++) begin
      if (use_ch1 ? ch1_out : pwm_out) hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hi, n, exp, prev;
    repeat (3) @(negedge clk);
    chk("R11 pwm_out reset", int'(pwm_out), 0);
    chk("R11 ch1_out reset", int'(ch1_out), 0);
    chk("R11 irq reset", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cnt_en = 1'b1;
    wr(3'd5, 1);

    // R1 / R3 / R4 sweep on channel 0, unlinked
    foreach (cur_mod_list[k]) ;
    for (int mi = 0; mi < 3; mi++) begin
      int m;
      m = (mi == 0) ? 3 : (mi == 1) ? 5 : 8;
      cur_mod = m;
      wr(3'd0, m);
      sync_wrap();
      wr(3'd6, 1);
      n = 1;
      while (!irq) begin n++; @(negedge clk); end
      chk("R1 period", n, m + 1);
      for (int pol = 0; pol < 2; pol++) begin
        wr(3'd3, pol ? 3 : 1);
        for (int c = 0; c <= m; c++) begin
          wr(3'd1, c);
          duty(1'b0, m, hi);
          exp = pol ? 4 * (c + 1) : 4 * (m + 1) - 4 * (c + 1);
          chk(c == m ? "R4 match at wrap" : "R3 duty ch0", hi, exp);
        end
      end
    end

    // R9 unlinked channel 1
    cur_mod = 5;
    wr(3'd0, 5);
    wr(3'd4, 3);
    for (int c = 0; c <= 5; c += 2) begin
      wr(3'd2, c);
      duty(1'b1, 5, hi);
      chk("R9 ch1 own duty", hi, 4 * (c + 1));
    end

    // R2 count enable low freezes everything
    wr(3'd3, 3);
    wr(3'd1, 2);
    sync_wrap();
    repeat (4) @(negedge clk);
    wr(3'd6, 1);
    cnt_en = 1'b0;
    prev = int'(pwm_out);
    n = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (int'(pwm_out) != prev || irq) n++;
    end
    chk("R2 frozen while disabled", n, 0);
    cnt_en = 1'b1;

    // buffered pair
    cur_mod = 9;
    wr(3'd0, 9);
    wr(3'd1, 2);
    wr(3'd2, 6);
    wr(3'd3, 7);
    sync_wrap();
    period(-1, 3'd0, 0, -1, 3'd0, 0, hi); chk("R5 reg0 active first", hi, 3);
    period(3, 3'd2, 6, -1, 3'd0, 0, hi);  chk("R6 no change mid-period", hi, 3);
    period(-1, 3'd0, 0, -1, 3'd0, 0, hi); chk("R6 switch at wrap", hi, 7);
    period(4, 3'd1, 4, -1, 3'd0, 0, hi);  chk("R6 reg1 kept", hi, 7);
    period(-1, 3'd0, 0, -1, 3'd0, 0, hi); chk("R6 back to reg0", hi, 5);
    period(1, 3'd1, 6, -1, 3'd0, 0, hi);  chk("R7 active write immediate", hi, 7);
    period(-1, 3'd0, 0, -1, 3'd0, 0, hi); chk("R7 active stays", hi, 7);
    period(2, 3'd2, 8, 5, 3'd1, 8, hi);   chk("R8 later write is reg0", hi, 9);
    period(-1, 3'd0, 0, -1, 3'd0, 0, hi); chk("R8 reg0 wins", hi, 9);
    period(2, 3'd1, 8, 5, 3'd2, 3, hi);   chk("R8 later write is reg1", hi, 9);
    period(-1, 3'd0, 0, -1, 3'd0, 0, hi); chk("R8 reg1 wins", hi, 4);

    // R9 GPIO drives channel 1 pin while linked
    wr(3'd7, 1);
    chk("R9 gpio high", int'(ch1_out), 1);
    wr(3'd7, 0);
    repeat (12) @(negedge clk);
    chk("R9 gpio low", int'(ch1_out), 0);

    // R5 relink restarts at reg0
    wr(3'd3, 3);
    wr(3'd3, 7);
    sync_wrap();
    period(-1, 3'd0, 0, -1, 3'd0, 0, hi); chk("R5 relink reg0", hi, 9);

    // R10 flag sticky, enable gates irq
    wr(3'd5, 0);
    repeat (25) @(negedge clk);
    chk("R10 irq masked", int'(irq), 0);
    wr(3'd5, 1);
    chk("R10 flag held", int'(irq), 1);
    sync_wrap();
    wr(3'd6, 0);
    chk("R10 zero write keeps flag", int'(irq), 1);
    wr(3'd6, 1);
    chk("R10 one write clears", int'(irq), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int cur_mod_list [1];
endmodule